// File: doc/BRIEF.md
# RTC Time Transaction Sequencer

This block runs whole time transactions against a real-time-clock chip whose registers each hold a single nibble. Date and time are kept in BCD. Each field is split into a units nibble and a tens nibble, and the two nibbles live at separate register addresses. The block sits above a serial master. It drives the chip-enable line itself and issues one register access at a time through a request/acknowledge interface, and the serial master turns each access into bus traffic.

A read command gets past the chip's adjust/busy flag, fetches every field and presents each one as an assembled BCD byte. A set command latches BCD bytes from its inputs and writes them back nibble by nibble. An init command checks the oscillator-stop flag. If that flag is set, the command reprograms the control and interval registers, waits out the busy flag, and loads a default time of midnight on day 01 of month 01, year 00. Each transaction ends with a one-cycle done pulse. Two status flags ride on that pulse: a timeout flag and an invalid-time-reset flag. The block does no binary conversion and no calendar checking.

Top module: `rtc_txn_seq`

## Requirements
- R1: During and right after reset, `rtc_ce`, `acc_req`, `busy` and `done` are low, and every time output reads zero.
- R2: `acc_req` is asserted only while `rtc_ce` is high. Once asserted, it holds `acc_wr`, `acc_addr` and `acc_wdata` steady until the cycle `acc_ack` is seen, and it is low in the next cycle.
- R3: A read or set begins with an access attempt. Chip enable goes high, 0x4 (24-hour mode) is written to control register 0xE, and 0xE is read back. If bit 0 of the returned nibble is clear, the field transfer starts.
- R4: If bit 0 is set, chip enable drops for at least GAP_CYC cycles and the attempt is repeated. When MAX_RETRY repeats have all found the flag set, the transaction ends with `err_timeout` and makes no field access. With the defaults this means 100 busy reads still succeed and 101 time out.
- R5: A read fetches addresses in the order 0,1 (seconds), 2,3 (minutes), 4,5 (hours), 8,9 (day), A,B (month), C,D (year), then 6 (weekday). The units nibble comes first in each pair, and each byte is assembled as tens<<4 | units.
- R6: A set writes the same addresses in the same order. Each pair takes the low nibble of its input byte first and then the high nibble, and the weekday nibble is written last.
- R7: Chip enable has been low for at least GAP_CYC cycles whenever it rises again and whenever `done` is high. `done` is a single-cycle pulse. `err_timeout` and `inv_reset` are meaningful only while `done` is high.
- R8: Init reads 0xE. If bit 1 is clear, init ends without a flag. If bit 1 is set, init writes 0x0 to 0x7 and then 0x7 to 0xE. It then reads 0xE until bit 0 is clear, up to POLL_MAX reads, and then performs a full set of 00:00:00, day 01, month 01, year 00, weekday 0, reporting `inv_reset` with done.
- R9: A command is accepted only while idle. When more than one is raised together, init wins over set and set wins over read. Commands raised while busy have no effect.
- R10: The time outputs hold the last transferred values: set inputs from acceptance, nibbles as they are read, or the init defaults. An init without the stop flag and a timed-out read leave them unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_read | input | 1 | Start a time read |
| cmd_set | input | 1 | Start a time set from the wr_* inputs |
| cmd_init | input | 1 | Start an oscillator-stop check and recovery |
| wr_sec | input | 8 | BCD seconds to set |
| wr_min | input | 8 | BCD minutes to set |
| wr_hour | input | 8 | BCD hours to set |
| wr_mday | input | 8 | BCD day of month to set |
| wr_mon | input | 8 | BCD month to set |
| wr_year | input | 8 | BCD two-digit year to set |
| wr_wday | input | 4 | Weekday nibble to set |
| busy | output | 1 | A transaction is in progress |
| done | output | 1 | One-cycle completion pulse |
| err_timeout | output | 1 | Busy flag never cleared (with done) |
| inv_reset | output | 1 | Time was reset to defaults (with done) |
| tm_sec | output | 8 | BCD seconds |
| tm_min | output | 8 | BCD minutes |
| tm_hour | output | 8 | BCD hours |
| tm_mday | output | 8 | BCD day of month |
| tm_mon | output | 8 | BCD month |
| tm_year | output | 8 | BCD year |
| tm_wday | output | 4 | Weekday nibble |
| rtc_ce | output | 1 | Chip enable to the clock chip |
| acc_req | output | 1 | Register access request to the serial master |
| acc_wr | output | 1 | Access is a write (1) or read (0) |
| acc_addr | output | 4 | Register address of the access |
| acc_wdata | output | 4 | Nibble to write |
| acc_ack | input | 1 | Access finished; acc_rdata valid |
| acc_rdata | input | 4 | Nibble returned by a read |

## Verification
Most faults in the phase register or the step index show up on the access stream within one access. A wrong address or a skipped or extra access is caught when the serial master acknowledges it. A miscounted retry or poll counter shows up only at the end of the transaction: the done pulse comes with the wrong flag, or there is one attempt too many or too few. A short chip-enable gap is seen the cycle chip enable rises again. A nibble stored in the wrong place is visible on the time outputs at the done pulse.

// File: rtl/rtc_seq_pkg.sv
package rtc_seq_pkg;

  typedef enum logic [2:0] {S_IDLE, S_LOAD, S_REQ, S_GAP, S_DONE} seq_st_t;
  typedef enum logic [1:0] {M_READ, M_SET, M_INIT} seq_mode_t;
  typedef enum logic [2:0] {
    P_ATT_W, P_ATT_R, P_FIELD, P_CHK, P_INIT_W7, P_INIT_WE, P_POLL
  } seq_phase_t;

  localparam int unsigned NSTEP  = 13;   // nibble accesses per full time transfer
  localparam int unsigned NFIELD = 7;

  localparam logic [3:0] A_CTRL    = 4'hE;
  localparam logic [3:0] A_INTV    = 4'h7;
  localparam logic [3:0] CTRL_24H  = 4'h4;
  localparam logic [3:0] CTRL_INIT = 4'h7;

  // Address of step idx: pairs 0..5, then 8..D, weekday at 6 last.
  function automatic logic [3:0] step_addr(input logic [3:0] idx);
    if (idx < 4'd6)       return idx;
    else if (idx < 4'd12) return idx + 4'd2;
    else                  return 4'h6;
  endfunction

  // Field slot 0..6 = sec, min, hour, mday, mon, year, wday.
  function automatic logic [2:0] step_field(input logic [3:0] idx);
    if (idx < 4'd12) return idx[3:1];
    else             return 3'd6;
  endfunction

  function automatic logic step_is_tens(input logic [3:0] idx);
    return (idx < 4'd12) && idx[0];
  endfunction

  function automatic logic [7:0] merge_nib(input logic [7:0] old,
                                           input logic [3:0] nib,
                                           input logic tens);
    return tens ? {nib, old[3:0]} : {old[7:4], nib};
  endfunction

endpackage

// File: rtl/rtc_gap_timer.sv
module rtc_gap_timer #(
  parameter int unsigned GAP_CYC = 70
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic run,
  output logic expired
);
  localparam int unsigned CW = $clog2(GAP_CYC + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)                     cnt <= '0;
    else if (start)                 cnt <= CW'(GAP_CYC - 1);
    else if (run && cnt != '0)      cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/rtc_step_map.sv
module rtc_step_map
  import rtc_seq_pkg::*;
(
  input  logic [3:0]      idx,
  input  logic [6:0][7:0] tm,
  output logic [3:0]      addr,
  output logic [3:0]      wdata,
  output logic [2:0]      fidx,
  output logic            tens
);
  always_comb begin
    addr  = step_addr(idx);
    fidx  = step_field(idx);
    tens  = step_is_tens(idx);
    wdata = tens ? tm[fidx][7:4] : tm[fidx][3:0];
  end
endmodule

// File: rtl/rtc_txn_seq.sv
module rtc_txn_seq
  import rtc_seq_pkg::*;
#(
  parameter int unsigned MAX_RETRY = 100,
  parameter int unsigned POLL_MAX  = 100,
  parameter int unsigned GAP_CYC   = 70
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_read,
  input  logic       cmd_set,
  input  logic       cmd_init,
  input  logic [7:0] wr_sec,
  input  logic [7:0] wr_min,
  input  logic [7:0] wr_hour,
  input  logic [7:0] wr_mday,
  input  logic [7:0] wr_mon,
  input  logic [7:0] wr_year,
  input  logic [3:0] wr_wday,
  output logic       busy,
  output logic       done,
  output logic       err_timeout,
  output logic       inv_reset,
  output logic [7:0] tm_sec,
  output logic [7:0] tm_min,
  output logic [7:0] tm_hour,
  output logic [7:0] tm_mday,
  output logic [7:0] tm_mon,
  output logic [7:0] tm_year,
  output logic [3:0] tm_wday,
  output logic       rtc_ce,
  output logic       acc_req,
  output logic       acc_wr,
  output logic [3:0] acc_addr,
  output logic [3:0] acc_wdata,
  input  logic       acc_ack,
  input  logic [3:0] acc_rdata
);
  localparam int unsigned RW = $clog2(MAX_RETRY + 1);
  localparam int unsigned PW = $clog2(POLL_MAX + 1);
  localparam logic [3:0]  LAST_STEP = 4'(NSTEP - 1);

  seq_st_t         st;
  seq_mode_t       mode;
  seq_phase_t      ph;
  logic            gap_retry;
  logic [3:0]      idx;
  logic [RW-1:0]   retry;
  logic [PW-1:0]   poll;
  logic            to_flag, inv_flag;
  logic [6:0][7:0] tm;

  logic [3:0] map_addr, map_wdata;
  logic [2:0] map_fidx;
  logic       map_tens;

  logic       nx_wr;
  logic [3:0] nx_addr, nx_wdata;

  // Named internal events
  logic ev_accept, ev_ack, ctrl_busy, ctrl_stop;
  logic ev_attempt_busy, ev_give_up, ev_last_field, ev_clean, ev_drop;
  logic ev_poll_end, gap_expired;

  assign ctrl_busy       = acc_rdata[0];
  assign ctrl_stop       = acc_rdata[1];
  assign ev_accept       = (st == S_IDLE) && (cmd_read || cmd_set || cmd_init);
  assign ev_ack          = (st == S_REQ) && acc_ack;
  assign ev_attempt_busy = ev_ack && (ph == P_ATT_R) && ctrl_busy;
  assign ev_give_up      = ev_attempt_busy && (retry == RW'(MAX_RETRY));
  assign ev_last_field   = ev_ack && (ph == P_FIELD) && (idx == LAST_STEP);
  assign ev_clean        = ev_ack && (ph == P_CHK) && !ctrl_stop;
  assign ev_poll_end     = ev_ack && (ph == P_POLL) &&
                           (!ctrl_busy || poll == PW'(POLL_MAX - 1));
  assign ev_drop         = ev_attempt_busy || ev_last_field || ev_clean;

  rtc_step_map u_map (
    .idx   (idx),
    .tm    (tm),
    .addr  (map_addr),
    .wdata (map_wdata),
    .fidx  (map_fidx),
    .tens  (map_tens)
  );

  rtc_gap_timer #(.GAP_CYC(GAP_CYC)) u_gap (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (ev_drop),
    .run     (st == S_GAP),
    .expired (gap_expired)
  );

  // Access chosen by the current phase
  always_comb begin
    nx_wr    = 1'b0;
    nx_addr  = A_CTRL;
    nx_wdata = 4'h0;
    unique case (ph)
      P_ATT_W:   begin nx_wr = 1'b1; nx_wdata = CTRL_24H; end
      P_INIT_W7: begin nx_wr = 1'b1; nx_addr = A_INTV; end
      P_INIT_WE: begin nx_wr = 1'b1; nx_wdata = CTRL_INIT; end
      P_FIELD:   begin
        nx_wr    = (mode == M_SET);
        nx_addr  = map_addr;
        nx_wdata = (mode == M_SET) ? map_wdata : 4'h0;
      end
      default:   ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      mode      <= M_READ;
      ph        <= P_ATT_W;
      gap_retry <= 1'b0;
      idx       <= '0;
      retry     <= '0;
      poll      <= '0;
      to_flag   <= 1'b0;
      inv_flag  <= 1'b0;
      tm        <= '0;
      rtc_ce    <= 1'b0;
      acc_req   <= 1'b0;
      acc_wr    <= 1'b0;
      acc_addr  <= '0;
      acc_wdata <= '0;
    end else begin
      unique case (st)
        S_IDLE: if (ev_accept) begin
          rtc_ce   <= 1'b1;
          st       <= S_LOAD;
          retry    <= '0;
          poll     <= '0;
          idx      <= '0;
          to_flag  <= 1'b0;
          inv_flag <= 1'b0;
          if (cmd_init) begin
            mode <= M_INIT;
            ph   <= P_CHK;
          end else if (cmd_set) begin
            mode <= M_SET;
            ph   <= P_ATT_W;
            tm   <= {4'h0, wr_wday, wr_year, wr_mon, wr_mday, wr_hour, wr_min, wr_sec};
          end else begin
            mode <= M_READ;
            ph   <= P_ATT_W;
          end
        end
        S_LOAD: begin
          acc_req   <= 1'b1;
          acc_wr    <= nx_wr;
          acc_addr  <= nx_addr;
          acc_wdata <= nx_wdata;
          st        <= S_REQ;
        end
        S_REQ: if (acc_ack) begin
          acc_req <= 1'b0;
          st      <= S_LOAD;
          unique case (ph)
            P_ATT_W: ph <= P_ATT_R;
            P_ATT_R: begin
              if (ctrl_busy) begin
                rtc_ce    <= 1'b0;
                st        <= S_GAP;
                gap_retry <= !ev_give_up;
                to_flag   <= ev_give_up;
              end else begin
                ph  <= P_FIELD;
                idx <= '0;
              end
            end
            P_FIELD: begin
              if (mode == M_READ)
                tm[map_fidx] <= merge_nib(tm[map_fidx], acc_rdata, map_tens);
              if (ev_last_field) begin
                rtc_ce    <= 1'b0;
                st        <= S_GAP;
                gap_retry <= 1'b0;
              end else begin
                idx <= idx + 1'b1;
              end
            end
            P_CHK: begin
              if (ctrl_stop) begin
                inv_flag <= 1'b1;
                ph       <= P_INIT_W7;
                tm       <= {8'h00, 8'h00, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00};
              end else begin
                rtc_ce    <= 1'b0;
                st        <= S_GAP;
                gap_retry <= 1'b0;
              end
            end
            P_INIT_W7: ph <= P_INIT_WE;
            P_INIT_WE: begin
              ph   <= P_POLL;
              poll <= '0;
            end
            P_POLL: begin
              if (ev_poll_end) begin
                mode  <= M_SET;
                ph    <= P_ATT_W;
                retry <= '0;
              end else begin
                poll <= poll + 1'b1;
              end
            end
            default: ;
          endcase
        end
        S_GAP: if (gap_expired) begin
          if (gap_retry) begin
            rtc_ce <= 1'b1;
            retry  <= retry + 1'b1;
            ph     <= P_ATT_W;
            st     <= S_LOAD;
          end else begin
            st <= S_DONE;
          end
        end
        S_DONE: st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign busy        = (st != S_IDLE);
  assign done        = (st == S_DONE);
  assign err_timeout = done && to_flag;
  assign inv_reset   = done && inv_flag;
  assign tm_sec      = tm[0];
  assign tm_min      = tm[1];
  assign tm_hour     = tm[2];
  assign tm_mday     = tm[3];
  assign tm_mon      = tm[4];
  assign tm_year     = tm[5];
  assign tm_wday     = tm[6][3:0];

endmodule

// File: rtl/rtc_seq_chk.sv
module rtc_seq_chk #(
  parameter int unsigned GAP_CYC = 70
) (
  input logic       clk,
  input logic       rst_n,
  input logic       rtc_ce,
  input logic       acc_req,
  input logic       acc_ack,
  input logic       acc_wr,
  input logic [3:0] acc_addr,
  input logic [3:0] acc_wdata,
  input logic       done,
  input logic       busy
);
  localparam int unsigned CW = $clog2(GAP_CYC + 1);

  logic [CW-1:0] lowcnt;

  always_ff @(posedge clk) begin
    if (!rst_n)                                lowcnt <= CW'(GAP_CYC);
    else if (rtc_ce)                           lowcnt <= '0;
    else if (lowcnt != CW'(GAP_CYC))           lowcnt <= lowcnt + 1'b1;
  end

  assert_req_under_ce_R2: assert property (@(posedge clk) disable iff (!rst_n)
    acc_req |-> rtc_ce);

  assert_req_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_req && !acc_ack) |=> (acc_req && $stable(acc_addr) && $stable(acc_wr)
                               && $stable(acc_wdata)));

  assert_req_drop_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_req && acc_ack) |=> !acc_req);

  assert_ce_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(rtc_ce) || done) |-> (lowcnt >= CW'(GAP_CYC)));

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_ce_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !rtc_ce);

  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!acc_req && !rtc_ce));
endmodule

bind rtc_txn_seq rtc_seq_chk #(.GAP_CYC(GAP_CYC)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .rtc_ce    (rtc_ce),
  .acc_req   (acc_req),
  .acc_ack   (acc_ack),
  .acc_wr    (acc_wr),
  .acc_addr  (acc_addr),
  .acc_wdata (acc_wdata),
  .done      (done),
  .busy      (busy)
);

// File: tb/sim_rtc_txn_seq.sv
module sim_rtc_txn_seq;
  localparam int MAXR = 100;
  localparam int POLLN = 100;
  localparam int GAP = 70;
  localparam int LAT = 2;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n = 1'b0;
  logic cmd_read = 0, cmd_set = 0, cmd_init = 0;
  logic [7:0] wr_sec = 0, wr_min = 0, wr_hour = 0, wr_mday = 0, wr_mon = 0, wr_year = 0;
  logic [3:0] wr_wday = 0;
  logic busy, done, err_timeout, inv_reset;
  logic [7:0] tm_sec, tm_min, tm_hour, tm_mday, tm_mon, tm_year;
  logic [3:0] tm_wday;
  logic rtc_ce, acc_req, acc_wr;
  logic [3:0] acc_addr, acc_wdata;
  logic ack_i = 1'b0;
  logic [3:0] rdata_i = 4'h0;

  rtc_txn_seq u0 (
    .clk(clk), .rst_n(rst_n), .cmd_read(cmd_read), .cmd_set(cmd_set), .cmd_init(cmd_init),
    .wr_sec(wr_sec), .wr_min(wr_min), .wr_hour(wr_hour), .wr_mday(wr_mday),
    .wr_mon(wr_mon), .wr_year(wr_year), .wr_wday(wr_wday),
    .busy(busy), .done(done), .err_timeout(err_timeout), .inv_reset(inv_reset),
    .tm_sec(tm_sec), .tm_min(tm_min), .tm_hour(tm_hour), .tm_mday(tm_mday),
    .tm_mon(tm_mon), .tm_year(tm_year), .tm_wday(tm_wday),
    .rtc_ce(rtc_ce), .acc_req(acc_req), .acc_wr(acc_wr), .acc_addr(acc_addr),
    .acc_wdata(acc_wdata), .acc_ack(ack_i), .acc_rdata(rdata_i)
  );

  int vecs = 0;
  int miss = 0;
  int exp_q[$];
  logic [3:0] sregs [16];
  int busy_left = 0;
  bit stop_bit = 0;
  logic [7:0] exp_tm [7];
  int ce_low = 1000;
  bit ce_prev = 0;
  int lat = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vecs++;
    if (!ok) begin
      miss++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
  endtask

  function automatic int enc(input int wr, input int a, input int d);
    return wr * 256 + a * 16 + d;
  endfunction

  // Behavioural clock chip plus per-clock comparison
  initial begin
    for (int k = 0; k < 16; k++) sregs[k] = 4'h0;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        chk(!acc_req || rtc_ce, "R2 request outside chip enable", acc_req, 0);
        if (rtc_ce && !ce_prev) chk(ce_low >= GAP, "R7 chip enable low time before rise", ce_low, GAP);
        if (done) chk(ce_low >= GAP, "R7 chip enable low time before done", ce_low, GAP);
        if (rtc_ce) ce_low = 0; else ce_low++;
        ce_prev = rtc_ce;
        if (ack_i) begin
          ack_i = 1'b0;
        end else if (acc_req) begin
          if (lat < LAT - 1) lat++;
          else begin
            int got, want;
            lat = 0;
            got = enc(acc_wr, acc_addr, acc_wr ? acc_wdata : 0);
            if (exp_q.size() == 0) begin
              chk(0, "R3/R5/R6/R8/R9 unexpected access", got, 0);
            end else begin
              want = exp_q.pop_front();
              chk(got == want, "R3/R5/R6/R8 access wr/addr/data", got, want);
            end
            if (acc_wr) begin
              if (acc_addr != 4'hE) sregs[acc_addr] = acc_wdata;
            end else if (acc_addr == 4'hE) begin
              rdata_i = {2'b01, stop_bit, busy_left > 0};
              if (busy_left > 0) busy_left--;
            end else begin
              rdata_i = sregs[acc_addr];
            end
            ack_i = 1'b1;
          end
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    chk(0, "watchdog expired", 0, 1);
    summary();
    $finish;
  end

  // Expected access list builders
  task automatic q_attempts(inout int bl, output bit ok);
    ok = 0;
    for (int a = 0; a <= MAXR; a++) begin
      exp_q.push_back(enc(1, 14, 4));
      exp_q.push_back(enc(0, 14, 0));
      if (bl > 0) bl--;
      else begin ok = 1; return; end
    end
  endtask

  task automatic q_fields(input bit wr);
    int ord[13] = '{0, 1, 2, 3, 4, 5, 8, 9, 10, 11, 12, 13, 6};
    for (int p = 0; p < 13; p++) begin
      int d;
      if (p == 12) d = exp_tm[6][3:0];
      else if (p % 2 == 1) d = exp_tm[p / 2][7:4];
      else d = exp_tm[p / 2][3:0];
      exp_q.push_back(enc(wr, ord[p], wr ? d : 0));
    end
  endtask

  task automatic issue(input bit r, input bit s, input bit i);
    @(negedge clk);
    cmd_read = r; cmd_set = s; cmd_init = i;
    @(negedge clk);
    cmd_read = 0; cmd_set = 0; cmd_init = 0;
  endtask

  task automatic wait_done(output bit got);
    got = 0;
    for (int n = 0; n < 40000; n++) begin
      if (done) begin got = 1; return; end
      @(negedge clk);
    end
  endtask

  task automatic end_checks(input bit eto, input bit einv, input string tag);
    chk(err_timeout == eto, {tag, " R4 timeout flag"}, err_timeout, eto);
    chk(inv_reset == einv, {tag, " R8 reset flag"}, inv_reset, einv);
    chk(exp_q.size() == 0, {tag, " R5/R6 accesses left over"}, exp_q.size(), 0);
    chk(tm_sec == exp_tm[0], {tag, " R10 seconds"}, tm_sec, exp_tm[0]);
    chk(tm_min == exp_tm[1], {tag, " R10 minutes"}, tm_min, exp_tm[1]);
    chk(tm_hour == exp_tm[2], {tag, " R10 hours"}, tm_hour, exp_tm[2]);
    chk(tm_mday == exp_tm[3], {tag, " R10 day"}, tm_mday, exp_tm[3]);
    chk(tm_mon == exp_tm[4], {tag, " R10 month"}, tm_mon, exp_tm[4]);
    chk(tm_year == exp_tm[5], {tag, " R10 year"}, tm_year, exp_tm[5]);
    chk(tm_wday == exp_tm[6][3:0], {tag, " R10 weekday"}, tm_wday, exp_tm[6]);
    exp_q.delete();
    @(negedge clk);
    chk(!done && !busy, {tag, " R7 done lasts one cycle"}, done, 0);
  endtask

  task automatic do_read(input int bl, input string tag);
    int m = bl;
    bit ok;
    q_attempts(m, ok);
    if (ok) begin
      for (int f = 0; f < 6; f++) exp_tm[f] = {sregs[2 * f + 1 + (f >= 3 ? 2 : 0)], sregs[2 * f + (f >= 3 ? 2 : 0)]};
      exp_tm[6] = {4'h0, sregs[6]};
      q_fields(0);
    end
    busy_left = bl;
    issue(1, 0, 0);
    begin bit g; wait_done(g); chk(g, {tag, " R3 completion seen"}, g, 1); end
    end_checks(!ok, 0, tag);
  endtask

  task automatic do_init(input bit stp, input int bl, input string tag);
    int m = bl;
    bit ok = 1;
    exp_q.push_back(enc(0, 14, 0));
    if (m > 0) m--;
    if (stp) begin
      exp_q.push_back(enc(1, 7, 0));
      exp_q.push_back(enc(1, 14, 7));
      for (int p = 0; p < POLLN; p++) begin
        exp_q.push_back(enc(0, 14, 0));
        if (m > 0) m--; else break;
      end
      exp_tm = '{8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h00, 8'h00};
      q_attempts(m, ok);
      if (ok) q_fields(1);
    end
    busy_left = bl;
    stop_bit = stp;
    issue(0, 0, 1);
    begin bit g; wait_done(g); chk(g, {tag, " R8 completion seen"}, g, 1); end
    end_checks(!ok, stp, tag);
    stop_bit = 0;
  endtask

  task automatic load_set_inputs(input logic [7:0] s, mi, h, d, mo, y, input logic [3:0] w);
    wr_sec = s; wr_min = mi; wr_hour = h; wr_mday = d; wr_mon = mo; wr_year = y; wr_wday = w;
    exp_tm = '{s, mi, h, d, mo, y, {4'h0, w}};
  endtask

  initial begin
    bit ok, g;
    int m;
    repeat (4) @(negedge clk);
    chk(!rtc_ce && !acc_req && !busy && !done, "R1 control outputs in reset", {rtc_ce, acc_req, busy, done}, 0);
    chk({tm_sec, tm_min, tm_hour, tm_mday, tm_mon, tm_year, tm_wday} == '0, "R1 time outputs in reset", tm_sec, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!rtc_ce && !busy, "R1 idle after reset", {rtc_ce, busy}, 0);

    // Set 23:59:58, day 31, month 12, year 99, weekday 6
    load_set_inputs(8'h58, 8'h59, 8'h23, 8'h31, 8'h12, 8'h99, 4'h6);
    m = 0; q_attempts(m, ok); q_fields(1);
    busy_left = 0;
    issue(0, 1, 0);
    wait_done(g); chk(g, "R6 set completion", g, 1);
    end_checks(0, 0, "set");
    chk(sregs[8] == 4'h1 && sregs[9] == 4'h3 && sregs[6] == 4'h6, "R6 chip day/weekday nibbles",
        {sregs[9], sregs[8]}, 8'h31);

    // Read back a different time placed in the chip
    sregs[0] = 4'h7; sregs[1] = 4'h4; sregs[2] = 4'h5; sregs[3] = 4'h0;
    sregs[4] = 4'h8; sregs[5] = 4'h1; sregs[8] = 4'h9; sregs[9] = 4'h0;
    sregs[10] = 4'h0; sregs[11] = 4'h1; sregs[12] = 4'h4; sregs[13] = 4'h2; sregs[6] = 4'h3;
    do_read(0, "read R5");
    do_read(3, "read busy3 R4");
    do_read(MAXR, "read busy_at_limit R4");
    do_read(MAXR + 1, "read busy_past_limit R4");

    do_init(0, 0, "init clean R8");
    do_init(1, 4, "init stopped R8");
    do_init(1, POLLN + 1, "init poll_exhausted R8");

    // R9: set and read together -> set; commands during busy ignored
    load_set_inputs(8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h06, 4'h2);
    m = 0; q_attempts(m, ok); q_fields(1);
    busy_left = 0;
    issue(1, 1, 0);
    repeat (10) @(negedge clk);
    wr_sec = 8'h77;
    issue(1, 0, 1);
    wait_done(g); chk(g, "R9 priority completion", g, 1);
    end_checks(0, 0, "prio R9");
    repeat (20) begin
      @(negedge clk);
      chk(!busy && !acc_req, "R9 command during busy was ignored", {busy, acc_req}, 0);
    end

    summary();
    $finish;
  end
endmodule